// File: doc/BRIEF.md
# Downstream Port Power and Overcurrent Manager

This block owns the power state of the downstream ports of a small hub with two to four ports. It drives one active-low enable line per port to an external power switch and watches one active-low overcurrent line coming back from each switch. Host feature commands, already decoded by the hub status logic into one-cycle pulses, turn port power on and off. A strap input chosen at configuration time selects between individual handling, where every port stands alone, and ganged handling, where all ports switch and report as one group.

Each overcurrent line is synchronised and then passes through a debounce filter whose length is a 4-bit count of milliseconds, counted from a 1 kHz tick enable. A fault that survives the filter removes power from its port, or from every port in ganged mode, with no host involvement. It also raises a sticky change flag that the hub status logic reports upstream and later clears. Only the onset of a fault is filtered. When the line returns high, the current-state output follows it through the synchroniser with no further delay.

Top module: `port_power_mgr`

## Requirements
- R1: After reset every `pwrEnN` bit is 1 (port unpowered), and every `ocState` and `ocChange` bit is 0.
- R2: In individual mode, a pulse on `setPower[i]` drives `pwrEnN[i]` low at the next clock edge and leaves the other ports unchanged.
- R3: In individual mode, a pulse on `clrPower[i]` drives `pwrEnN[i]` high at the next clock edge. When `setPower[i]` and `clrPower[i]` are high in the same cycle, the clear wins.
- R4: In ganged mode, any set bit powers every port and any clear bit unpowers every port, at the next edge. The enables of all ports are always equal.
- R5: With `filterMs` = F > 0, `ocState[i]` rises only after `ocN[i]` has been low through F `msTick` pulses, counted from the cycle the synchronised fault is seen. A low pulse that ends before the F-th tick leaves `ocState`, `ocChange` and `pwrEnN` untouched. `ocState[i]` rises at the edge that captures the F-th tick.
- R6: With `filterMs` = 0 there is no filtering: `ocState[i]` rises at the third clock edge after `ocN[i]` goes low.
- R7: A confirmed fault sets `pwrEnN[i]` high one edge after `ocState[i]` rises, with no host command. In ganged mode every port goes off.
- R8: `ocChange[i]` rises on the same edge as the power drop of R7. It stays at 1 until a pulse on `clrOcChange[i]`, which clears it at the next edge.
- R9: In ganged mode a fault on any `ocN` bit drives all `ocState` and all `ocChange` bits together, and any `clrOcChange` bit clears every change bit.
- R10: When `ocN[i]` returns high, `ocState[i]` falls at the third clock edge after, whatever `filterMs` is.
- R11: A set request for a port whose `ocState` bit is 1 has no effect. Once the fault has cleared, a new set request powers the port again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gangMode | input | 1 | 1: ganged switching and reporting; 0: per port. Static outside reset |
| filterMs | input | FILT_W | Overcurrent debounce length in ms ticks; 0 disables the filter |
| msTick | input | 1 | One-cycle pulse every millisecond |
| setPower | input | NUM_PORTS | Host request pulse: power the port on |
| clrPower | input | NUM_PORTS | Host request pulse: power the port off |
| clrOcChange | input | NUM_PORTS | Host request pulse: clear the overcurrent change flag |
| ocN | input | NUM_PORTS | Active-low overcurrent report from the external switches |
| pwrEnN | output | NUM_PORTS | Active-low power enable to the external switches |
| ocState | output | NUM_PORTS | Filtered current overcurrent state, active high |
| ocChange | output | NUM_PORTS | Sticky overcurrent change flag, active high |

## Verification
A wrong debounce count shows at `ocState` at the edge where the F-th tick should confirm the fault: the output changes one tick too early or too late, or a short glitch gets through. A wrong power or change register shows at `pwrEnN` or `ocChange` one edge after the command or confirmation that should have moved it. A port left powered under a fault is seen on the very next edge. Ganged-mode mistakes show as unequal bits within one output vector. The reference model is compared against all three outputs on every cycle, so any divergence is reported in the cycle where it first appears.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  // Per-port commands from the control to the datapath registers.
  typedef struct packed {
    logic pwrOn;   // request power on
    logic pwrOff;  // force power off (wins over pwrOn)
    logic chgSet;  // raise overcurrent change flag
    logic chgClr;  // clear overcurrent change flag (loses to chgSet)
  } portStrobe_t;

endpackage

// File: rtl/ppm_filter.sv
module ppm_filter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             faultIn,
  input  logic             msTick,
  input  logic [CNT_W-1:0] limit,
  output logic             confirmed
);

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] tickCntNext;

  // Count ticks while the fault persists; any release restarts the count.
  always_comb begin
    tickCntNext = tickCnt;
    if (!faultIn)
      tickCntNext = '0;
    else if (msTick && (tickCnt < limit))
      tickCntNext = tickCnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt   <= '0;
      confirmed <= 1'b0;
    end else begin
      tickCnt   <= tickCntNext;
      confirmed <= faultIn && (tickCntNext >= limit);
    end
  end

  // R10: once the filtered input is gone, the confirmation is gone one edge later.
  a_r10_release_fast: assert property (@(posedge clk) disable iff (!rstN)
    !faultIn |=> !confirmed);

endmodule

// File: rtl/ppm_datapath.sv
module ppm_datapath
  import ppm_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int FILT_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 gangMode,
  input  logic                 msTick,
  input  logic [FILT_W-1:0]    filterMs,
  input  logic [NUM_PORTS-1:0] ocN,
  input  portStrobe_t          strobes [NUM_PORTS],
  output logic [NUM_PORTS-1:0] faultConf,
  output logic [NUM_PORTS-1:0] pwrEnN,
  output logic [NUM_PORTS-1:0] ocChange
);

  logic [NUM_PORTS-1:0] syncA;
  logic [NUM_PORTS-1:0] syncB;
  logic [NUM_PORTS-1:0] filtIn;
  logic [NUM_PORTS-1:0] pwrOn;
  logic [NUM_PORTS-1:0] chgFlag;
  logic                 anyFault;

  // Two-flop synchroniser, stored active high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= ~ocN;
      syncB <= syncA;
    end
  end

  assign anyFault = |syncB;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign filtIn[p] = gangMode ? anyFault : syncB[p];

    ppm_filter #(.CNT_W(FILT_W)) u_filt (
      .clk      (clk),
      .rstN     (rstN),
      .faultIn  (filtIn[p]),
      .msTick   (msTick),
      .limit    (filterMs),
      .confirmed(faultConf[p])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pwrOn[p]   <= 1'b0;
        chgFlag[p] <= 1'b0;
      end else begin
        if (strobes[p].pwrOff)
          pwrOn[p] <= 1'b0;
        else if (strobes[p].pwrOn)
          pwrOn[p] <= 1'b1;
        if (strobes[p].chgSet)
          chgFlag[p] <= 1'b1;
        else if (strobes[p].chgClr)
          chgFlag[p] <= 1'b0;
      end
    end
  end

  assign pwrEnN   = ~pwrOn;
  assign ocChange = chgFlag;

  // R4: ganged ports never differ in power state.
  a_r4_gang_uniform: assert property (@(posedge clk) disable iff (!rstN)
    gangMode |-> (pwrOn == '0 || pwrOn == '1));

endmodule

// File: rtl/ppm_ctrl.sv
module ppm_ctrl
  import ppm_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 gangMode,
  input  logic [NUM_PORTS-1:0] setPower,
  input  logic [NUM_PORTS-1:0] clrPower,
  input  logic [NUM_PORTS-1:0] clrOcChange,
  input  logic [NUM_PORTS-1:0] faultConf,
  output portStrobe_t          strobes [NUM_PORTS]
);

  logic [NUM_PORTS-1:0] confPrev;
  logic [NUM_PORTS-1:0] confRise;
  logic anySet, anyClr, anyChgClr, anyConf, anyRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) confPrev <= '0;
    else       confPrev <= faultConf;
  end

  assign confRise  = faultConf & ~confPrev;
  assign anySet    = |setPower;
  assign anyClr    = |clrPower;
  assign anyChgClr = |clrOcChange;
  assign anyConf   = |faultConf;
  assign anyRise   = |confRise;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    logic reqSet, reqClr, fault;
    assign reqSet = gangMode ? anySet  : setPower[p];
    assign reqClr = gangMode ? anyClr  : clrPower[p];
    assign fault  = gangMode ? anyConf : faultConf[p];

    always_comb begin
      strobes[p].pwrOff = reqClr | fault;
      strobes[p].pwrOn  = reqSet & ~fault;
      strobes[p].chgSet = gangMode ? anyRise : confRise[p];
      strobes[p].chgClr = gangMode ? anyChgClr : clrOcChange[p];
    end
  end

endmodule

// File: rtl/port_power_mgr.sv
module port_power_mgr
  import ppm_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int FILT_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 gangMode,
  input  logic [FILT_W-1:0]    filterMs,
  input  logic                 msTick,
  input  logic [NUM_PORTS-1:0] setPower,
  input  logic [NUM_PORTS-1:0] clrPower,
  input  logic [NUM_PORTS-1:0] clrOcChange,
  input  logic [NUM_PORTS-1:0] ocN,
  output logic [NUM_PORTS-1:0] pwrEnN,
  output logic [NUM_PORTS-1:0] ocState,
  output logic [NUM_PORTS-1:0] ocChange
);

  portStrobe_t          strobes [NUM_PORTS];
  logic [NUM_PORTS-1:0] faultConf;

  ppm_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .gangMode   (gangMode),
    .setPower   (setPower),
    .clrPower   (clrPower),
    .clrOcChange(clrOcChange),
    .faultConf  (faultConf),
    .strobes    (strobes)
  );

  ppm_datapath #(.NUM_PORTS(NUM_PORTS), .FILT_W(FILT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .gangMode (gangMode),
    .msTick   (msTick),
    .filterMs (filterMs),
    .ocN      (ocN),
    .strobes  (strobes),
    .faultConf(faultConf),
    .pwrEnN   (pwrEnN),
    .ocChange (ocChange)
  );

  assign ocState = faultConf;

  // R9: ganged reporting keeps every state bit equal.
  a_r9_gang_report: assert property (@(posedge clk) disable iff (!rstN)
    gangMode |-> (ocState == '0 || ocState == '1));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    // R7: a confirmed fault leaves the port unpowered on the next edge.
    a_r7_fault_off: assert property (@(posedge clk) disable iff (!rstN)
      ocState[p] |=> pwrEnN[p]);
    // R8: the change flag holds until the host clears it.
    a_r8_change_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (ocChange[p] && clrOcChange == '0) |=> ocChange[p]);
    // R5: in individual mode a fault only rises if the line was low three edges back.
    a_r5_rise_needs_input: assert property (@(posedge clk) disable iff (!rstN)
      (!gangMode && $rose(ocState[p])) |-> !$past(ocN[p], 3));
    // R11: no power while a fault is confirmed.
    a_r11_no_power_in_fault: assert property (@(posedge clk) disable iff (!rstN)
      (ocState[p] && pwrEnN[p]) |=> pwrEnN[p]);
  end

endmodule

// File: tb/sim_port_power_mgr.sv
`timescale 1ns/1ps
module sim_port_power_mgr;

  localparam int N = 3;
  localparam int FW = 4;

  logic clk = 1'b0;
  logic rstN;
  logic gangMode;
  logic [FW-1:0] filterMs;
  logic msTick;
  logic [N-1:0] setPower, clrPower, clrOcChange, ocN;
  logic [N-1:0] pwrEnN, ocState, ocChange;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  port_power_mgr #(.NUM_PORTS(N), .FILT_W(FW)) u0 (
    .clk(clk), .rstN(rstN), .gangMode(gangMode), .filterMs(filterMs),
    .msTick(msTick), .setPower(setPower), .clrPower(clrPower),
    .clrOcChange(clrOcChange), .ocN(ocN), .pwrEnN(pwrEnN),
    .ocState(ocState), .ocChange(ocChange)
  );

  // Behavioural reference model, one update per clock edge.
  int mLineSeen [N];   // line low seen by first capture stage
  int mLineUsed [N];   // line low as seen by the filter
  int mTicks [N];
  int mFault [N];
  int mFaultOld [N];
  int mPower [N];
  int mFlag [N];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        mLineSeen[i] = 0; mLineUsed[i] = 0; mTicks[i] = 0;
        mFault[i] = 0; mFaultOld[i] = 0; mPower[i] = 0; mFlag[i] = 0;
      end
    end else begin
      int groupFault, groupNew, groupSet, groupClr, groupAck, groupLine;
      groupFault = 0; groupNew = 0; groupLine = 0;
      groupSet = (setPower != 0); groupClr = (clrPower != 0);
      groupAck = (clrOcChange != 0);
      for (int i = 0; i < N; i++) begin
        if (mFault[i] != 0) groupFault = 1;
        if (mFault[i] != 0 && mFaultOld[i] == 0) groupNew = 1;
        if (mLineUsed[i] != 0) groupLine = 1;
      end
      for (int i = 0; i < N; i++) begin
        int f, s, c, n, a, line, want;
        f = gangMode ? groupFault : mFault[i];
        s = gangMode ? groupSet : int'(setPower[i]);
        c = gangMode ? groupClr : int'(clrPower[i]);
        n = gangMode ? groupNew : int'(mFault[i] != 0 && mFaultOld[i] == 0);
        a = gangMode ? groupAck : int'(clrOcChange[i]);
        if (f != 0 || c != 0) mPower[i] = 0;
        else if (s != 0) mPower[i] = 1;
        if (n != 0) mFlag[i] = 1;
        else if (a != 0) mFlag[i] = 0;
        mFaultOld[i] = mFault[i];
        line = gangMode ? groupLine : mLineUsed[i];
        if (line == 0) mTicks[i] = 0;
        else if (msTick && mTicks[i] < int'(filterMs)) mTicks[i]++;
        want = (line != 0 && mTicks[i] >= int'(filterMs)) ? 1 : 0;
        mFault[i] = want;
      end
      for (int i = 0; i < N; i++) begin
        mLineUsed[i] = mLineSeen[i];
        mLineSeen[i] = ocN[i] ? 0 : 1;
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      logic [N-1:0] ePwr, eSt, eChg;
      for (int i = 0; i < N; i++) begin
        ePwr[i] = (mPower[i] == 0);
        eSt[i]  = (mFault[i] != 0);
        eChg[i] = (mFlag[i] != 0);
      end
      chk("model R2 R3 R4 R7 R11", "pwrEnN", pwrEnN, ePwr);
      chk("model R5 R6 R9 R10", "ocState", ocState, eSt);
      chk("model R8 R9", "ocChange", ocChange, eChg);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulseSet(input logic [N-1:0] m);
    setPower = m; step(1); setPower = '0;
  endtask

  task automatic pulseClr(input logic [N-1:0] m);
    clrPower = m; step(1); clrPower = '0;
  endtask

  task automatic pulseAck(input logic [N-1:0] m);
    clrOcChange = m; step(1); clrOcChange = '0;
  endtask

  task automatic tick();
    msTick = 1'b1; step(1); msTick = 1'b0;
  endtask

  task automatic expectAll(input string tag, input logic [N-1:0] ePwr,
                           input logic [N-1:0] eSt, input logic [N-1:0] eChg);
    chk(tag, "pwrEnN", pwrEnN, ePwr);
    chk(tag, "ocState", ocState, eSt);
    chk(tag, "ocChange", ocChange, eChg);
  endtask

  initial begin
    #(200000 * 8);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; gangMode = 1'b0; filterMs = '0; msTick = 1'b0;
    setPower = '0; clrPower = '0; clrOcChange = '0; ocN = '1;
    step(3);
    rstN = 1'b1;
    step(1);
    expectAll("R1", 3'b111, 3'b000, 3'b000);

    // Individual switching
    pulseSet(3'b010);
    expectAll("R2", 3'b101, 3'b000, 3'b000);
    pulseSet(3'b001);
    expectAll("R2", 3'b100, 3'b000, 3'b000);
    setPower = 3'b100; clrPower = 3'b010; step(1); setPower = '0; clrPower = '0;
    expectAll("R3", 3'b010, 3'b000, 3'b000);
    setPower = 3'b001; clrPower = 3'b001; step(1); setPower = '0; clrPower = '0;
    expectAll("R3", 3'b011, 3'b000, 3'b000);

    // Unfiltered fault on port 2
    ocN = 3'b011;
    step(2);
    chk("R6", "ocState early", ocState, 3'b000);
    step(1);
    expectAll("R6", 3'b011, 3'b100, 3'b000);
    step(1);
    expectAll("R7 R8", 3'b111, 3'b100, 3'b100);
    pulseSet(3'b100);
    expectAll("R11", 3'b111, 3'b100, 3'b100);
    ocN = 3'b111;
    step(2);
    chk("R10", "ocState early", ocState, 3'b100);
    step(1);
    expectAll("R10 R8", 3'b111, 3'b000, 3'b100);
    pulseAck(3'b100);
    expectAll("R8", 3'b111, 3'b000, 3'b000);
    pulseSet(3'b100);
    expectAll("R11", 3'b011, 3'b000, 3'b000);

    // Filtered faults on port 0
    filterMs = 4'd3;
    pulseSet(3'b111);
    ocN = 3'b110;
    step(3);
    tick(); step(1); tick();
    ocN = 3'b111;
    step(4);
    expectAll("R5 glitch", 3'b000, 3'b000, 3'b000);
    ocN = 3'b110;
    step(3);
    tick(); step(2); tick(); step(1);
    expectAll("R5 before", 3'b000, 3'b000, 3'b000);
    tick();
    expectAll("R5 confirm", 3'b000, 3'b001, 3'b000);
    step(1);
    expectAll("R7", 3'b001, 3'b001, 3'b001);
    ocN = 3'b111;
    step(3);
    expectAll("R10", 3'b001, 3'b000, 3'b001);
    pulseAck(3'b001);

    // Ganged mode
    rstN = 1'b0; gangMode = 1'b1; filterMs = '0;
    step(2);
    rstN = 1'b1;
    step(1);
    expectAll("R1 gang", 3'b111, 3'b000, 3'b000);
    pulseSet(3'b010);
    expectAll("R4", 3'b000, 3'b000, 3'b000);
    pulseClr(3'b100);
    expectAll("R4", 3'b111, 3'b000, 3'b000);
    pulseSet(3'b001);
    expectAll("R4", 3'b000, 3'b000, 3'b000);
    ocN = 3'b101;
    step(3);
    expectAll("R9", 3'b000, 3'b111, 3'b000);
    step(1);
    expectAll("R9 R7", 3'b111, 3'b111, 3'b111);
    ocN = 3'b111;
    step(3);
    expectAll("R9 R10", 3'b111, 3'b000, 3'b111);
    pulseAck(3'b001);
    expectAll("R9 ack", 3'b111, 3'b000, 3'b000);
    pulseSet(3'b100);
    expectAll("R11 gang", 3'b000, 3'b000, 3'b000);
    step(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule